// File: doc/BRIEF.md
# Dual-Agent Strobe and Handshake Transfer Unit

This block moves one data word at a time between a sending agent and a receiving agent that are treated as if they had no common timing. Both agents sit in one clocked module. Each control line that crosses from one agent to the other passes through a two-flop synchronizer. The data bus passes through a matching two-stage delay line, so it arrives at the receiver aligned with the control line that qualifies it.

Four transfer disciplines can be chosen at runtime:
- The sender pushes with a strobe of fixed width.
- The receiver pulls with a strobe of fixed length.
- The sender pushes with a request and acknowledge exchange.
- The receiver pulls with a request and data-ready exchange.

Fixed delays are given as parameters counted in clock cycles. Both handshake styles are four-phase, and either side may stall a handshaked transfer for as long as it needs. A one-cycle completion pulse and the captured word are presented on the receiving side. The internal lines between the agents are brought out as outputs for observation.

Top module: `hs_xfer_unit`

## Requirements
- R1: After reset, `busy`, `xfer_done`, both link control lines and `link_data_en` are low, and `rx_word` and `link_data` are zero.
- R2: `mode_sel` is sampled only on an edge where `go` is high and `busy` is low, and that edge starts a transfer. The encoding is 2'b00 sender strobe, 2'b01 receiver strobe, 2'b10 sender handshake and 2'b11 receiver handshake. Changes on `mode_sel` or `go` while busy have no effect on the running transfer. A `go` on the edge where `busy` falls is ignored.
- R3: Sender strobe, with the start edge counted as edge 0. The sender drives the word taken at edge 0 and raises its strobe at edge 1 for STB_CYC cycles. `xfer_done` is high after edge 4, and `busy` falls after edge 4+STB_CYC.
- R4: Receiver strobe. The receiver raises its strobe at edge 0. The sender presents the `src_word` seen at edge 3+RESP_CYC. The receiver captures at edge T=5+RESP_CYC+SETTLE_CYC and drops its strobe there. The sender releases the bus at T+3, when `busy` falls.
- R5: Sender handshake. The receiver captures at the first edge E at or after 4+SETTLE_CYC at which `dst_stall` was low, and raises its acknowledge there. `busy` falls after E+9.
- R6: Receiver handshake. The sender presents the word and raises data-ready at the first edge F at or after 3+RESP_CYC at which `src_stall` was low. The receiver captures at C=F+3+SETTLE_CYC, and `busy` falls after C+6.
- R7: In both handshake styles the requester drops its line only while the peer's response line is high. `busy` stays high until every link line has returned low.
- R8: `xfer_done` is high for exactly one cycle per transfer, and only while `busy` is high. `rx_word` holds the captured word until the next capture.
- R9: `link_data` is zero whenever `link_data_en` is low, and it does not change while `link_data_en` stays high.
- R10: `src_stall` and `dst_stall` have no effect in the two strobe styles. `src_stall` has no effect in sender handshake, and `dst_stall` has no effect in receiver handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Transfer discipline for the next transfer |
| go | input | 1 | Start request, taken when idle |
| src_word | input | DATA_W | Word offered by the sending agent |
| src_stall | input | 1 | Sender not ready (receiver handshake only) |
| dst_stall | input | 1 | Receiver not ready (sender handshake only) |
| busy | output | 1 | A transfer is in progress in either agent |
| xfer_done | output | 1 | One-cycle pulse after a capture |
| rx_word | output | DATA_W | Last captured word |
| link_src_ctl | output | 1 | Sender line: strobe, request or data-ready |
| link_dst_ctl | output | 1 | Receiver line: strobe, acknowledge or request |
| link_data | output | DATA_W | Word on the link bus, zero when not driven |
| link_data_en | output | 1 | Sender is driving the link bus |

## Verification
Two collisions are provoked. In the first, a new start request meets the release of the previous transfer. `go` is held high across the edge where `busy` falls, and a reference model predicts that this edge refuses the request and the following edge accepts it with the mode then on `mode_sel`. In the second, the release of a stall meets the expiry of the fixed settling or response count. Stalls are lifted both before and after the count ends, and the model predicts the exact capture edge in each case. Every cycle, the model's `busy`, `xfer_done` and `rx_word` are compared with the outputs.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;

  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    XM_SRC_STROBE = 2'b00,
    XM_DST_STROBE = 2'b01,
    XM_SRC_HSHAKE = 2'b10,
    XM_DST_HSHAKE = 2'b11
  } xfer_mode_t;

  function automatic logic is_dst_init(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic is_hshake(input logic [1:0] m);
    return m[1];
  endfunction

  // receiver-strobe window: sync + response + data pipe + settle
  function automatic int pull_window(input int resp, input int settle);
    return resp + settle + SYNC_STAGES + 3;
  endfunction

  function automatic int cnt_width(input int a, input int b);
    return $clog2(((a > b) ? a : b) + 1);
  endfunction

endpackage

// File: rtl/hs_sync_chain.sv
module hs_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= 1'b0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= 1'b0;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hs_src_agent.sv
module hs_src_agent
  import hs_xfer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STB_CYC  = 4,
  parameter int RESP_CYC = 2,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              peer_sync,
  input  logic              stall,
  input  logic [DATA_W-1:0] word,
  output logic              ctl,
  output logic [DATA_W-1:0] data,
  output logic              data_en,
  output logic              busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_STB, S_WACK, S_WLOW, S_RESP, S_HOLD
  } src_st_t;

  src_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic             resp_ready;

  assign resp_ready = (cnt == '0) && (!is_hshake(mode) || !stall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      ctl     <= 1'b0;
      data    <= '0;
      data_en <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            data    <= word;
            data_en <= 1'b1;
            st      <= S_SETUP;
          end else if (is_dst_init(mode) && peer_sync) begin
            cnt <= CNT_W'(RESP_CYC - 1);
            st  <= S_RESP;
          end
        end
        S_SETUP: begin
          ctl <= 1'b1;
          if (is_hshake(mode)) st <= S_WACK;
          else begin
            cnt <= CNT_W'(STB_CYC - 1);
            st  <= S_STB;
          end
        end
        S_STB: begin
          if (cnt == '0) begin
            ctl     <= 1'b0;
            data    <= '0;
            data_en <= 1'b0;
            st      <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        S_WACK: begin
          if (peer_sync) begin
            ctl     <= 1'b0;
            data    <= '0;
            data_en <= 1'b0;
            st      <= S_WLOW;
          end
        end
        S_WLOW: if (!peer_sync) st <= S_IDLE;
        S_RESP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (resp_ready) begin
            data    <= word;
            data_en <= 1'b1;
            ctl     <= is_hshake(mode);
            st      <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (!peer_sync) begin
            ctl     <= 1'b0;
            data    <= '0;
            data_en <= 1'b0;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/hs_dst_agent.sv
module hs_dst_agent
  import hs_xfer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 3,
  parameter int WINDOW     = 10,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              peer_sync,
  input  logic              stall,
  input  logic [DATA_W-1:0] bus,
  output logic              ctl,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              busy
);
  typedef enum logic [2:0] {
    D_IDLE, D_STB, D_WRDY, D_SETTLE, D_ACK, D_WLOW
  } dst_st_t;

  dst_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] dpipe [SYNC_STAGES];
  logic             capture;
  logic             settle_ok;

  // data delay line, same depth as the control synchronizer
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_dpipe
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) dpipe[0] <= '0;
          else        dpipe[0] <= bus;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) dpipe[i] <= '0;
          else        dpipe[i] <= dpipe[i-1];
      end
    end
  endgenerate

  assign settle_ok = (cnt == '0) && (is_dst_init(mode) || !stall);

  always_comb begin
    capture = 1'b0;
    case (st)
      D_IDLE:   capture = !start && !is_dst_init(mode) && !is_hshake(mode) && peer_sync;
      D_STB:    capture = (cnt == '0);
      D_SETTLE: capture = settle_ok;
      default:  capture = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word <= '0;
      done    <= 1'b0;
    end else begin
      done <= capture;
      if (capture) rx_word <= dpipe[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= D_IDLE;
      cnt <= '0;
      ctl <= 1'b0;
    end else begin
      case (st)
        D_IDLE: begin
          if (start) begin
            ctl <= 1'b1;
            if (is_hshake(mode)) st <= D_WRDY;
            else begin
              cnt <= CNT_W'(WINDOW - 1);
              st  <= D_STB;
            end
          end else if (!is_dst_init(mode) && peer_sync) begin
            if (is_hshake(mode)) begin
              cnt <= CNT_W'(SETTLE_CYC - 1);
              st  <= D_SETTLE;
            end else st <= D_WLOW;
          end
        end
        D_STB: begin
          if (cnt == '0) begin
            ctl <= 1'b0;
            st  <= D_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        D_WRDY: begin
          if (peer_sync) begin
            cnt <= CNT_W'(SETTLE_CYC - 1);
            st  <= D_SETTLE;
          end
        end
        D_SETTLE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (settle_ok) begin
            if (is_dst_init(mode)) begin
              ctl <= 1'b0;
              st  <= D_WLOW;
            end else begin
              ctl <= 1'b1;
              st  <= D_ACK;
            end
          end
        end
        D_ACK: begin
          if (!peer_sync) begin
            ctl <= 1'b0;
            st  <= D_IDLE;
          end
        end
        D_WLOW: if (!peer_sync) st <= D_IDLE;
        default: st <= D_IDLE;
      endcase
    end
  end

  assign busy = (st != D_IDLE);
endmodule

// File: rtl/hs_xfer_unit.sv
module hs_xfer_unit
  import hs_xfer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STB_CYC    = 4,
  parameter int RESP_CYC   = 2,
  parameter int SETTLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              go,
  input  logic [DATA_W-1:0] src_word,
  input  logic              src_stall,
  input  logic              dst_stall,
  output logic              busy,
  output logic              xfer_done,
  output logic [DATA_W-1:0] rx_word,
  output logic              link_src_ctl,
  output logic              link_dst_ctl,
  output logic [DATA_W-1:0] link_data,
  output logic              link_data_en
);
  localparam int WINDOW = pull_window(RESP_CYC, SETTLE_CYC);
  localparam int CNT_W  = cnt_width(STB_CYC > RESP_CYC ? STB_CYC : RESP_CYC,
                                    WINDOW > SETTLE_CYC ? WINDOW : SETTLE_CYC);

  logic [1:0] mode_q;
  logic [1:0] mode_eff;
  logic       start;
  logic       start_src;
  logic       start_dst;
  logic       src_busy;
  logic       dst_busy;
  logic       src_ctl_at_dst;
  logic       dst_ctl_at_src;

  assign busy      = src_busy | dst_busy;
  assign start     = go & ~busy;
  assign start_src = start & ~is_dst_init(mode_sel);
  assign start_dst = start &  is_dst_init(mode_sel);
  assign mode_eff  = busy ? mode_q : mode_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     mode_q <= XM_SRC_STROBE;
    else if (start) mode_q <= mode_sel;

  hs_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_s2d (
    .clk(clk), .rst_n(rst_n), .d(link_src_ctl), .q(src_ctl_at_dst));

  hs_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_d2s (
    .clk(clk), .rst_n(rst_n), .d(link_dst_ctl), .q(dst_ctl_at_src));

  hs_src_agent #(
    .DATA_W(DATA_W), .STB_CYC(STB_CYC), .RESP_CYC(RESP_CYC), .CNT_W(CNT_W)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .start(start_src), .mode(mode_eff),
    .peer_sync(dst_ctl_at_src), .stall(src_stall), .word(src_word),
    .ctl(link_src_ctl), .data(link_data), .data_en(link_data_en),
    .busy(src_busy));

  hs_dst_agent #(
    .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC), .WINDOW(WINDOW), .CNT_W(CNT_W)
  ) u_dst (
    .clk(clk), .rst_n(rst_n), .start(start_dst), .mode(mode_eff),
    .peer_sync(src_ctl_at_dst), .stall(dst_stall), .bus(link_data),
    .ctl(link_dst_ctl), .done(xfer_done), .rx_word(rx_word),
    .busy(dst_busy));
endmodule

// File: rtl/hs_xfer_chk.sv
module hs_xfer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              xfer_done,
  input logic              link_src_ctl,
  input logic              link_dst_ctl,
  input logic [DATA_W-1:0] link_data,
  input logic              link_data_en,
  input logic [1:0]        mode_q
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R8
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> busy);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));

  // R7
  push_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(link_src_ctl) && mode_q == 2'b10) |-> link_dst_ctl);

  // R7
  pull_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(link_dst_ctl) && mode_q == 2'b11) |-> link_src_ctl);

  // R9
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_data_en |-> (link_data == '0));

  // R9
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_data_en && $past(link_data_en)) |-> $stable(link_data));

  // R7
  lines_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!link_src_ctl && !link_dst_ctl));
endmodule

bind hs_xfer_unit hs_xfer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .xfer_done(xfer_done),
  .link_src_ctl(link_src_ctl), .link_dst_ctl(link_dst_ctl),
  .link_data(link_data), .link_data_en(link_data_en), .mode_q(mode_q));

// File: tb/hs_xfer_unit_tb.sv
module hs_xfer_unit_tb;
  localparam int DW = 8;
  localparam int SW = 3;
  localparam int RD = 2;
  localparam int ST = 2;
  localparam int PULL_T = RD + ST + 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = 2'b00;
  logic          go = 1'b0;
  logic [DW-1:0] src_word = '0;
  logic          src_stall = 1'b0;
  logic          dst_stall = 1'b0;
  logic          busy, xfer_done, link_src_ctl, link_dst_ctl, link_data_en;
  logic [DW-1:0] rx_word, link_data;

  always #2.5 clk = ~clk;

  hs_xfer_unit #(.DATA_W(DW), .STB_CYC(SW), .RESP_CYC(RD), .SETTLE_CYC(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .go(go), .src_word(src_word),
    .src_stall(src_stall), .dst_stall(dst_stall), .busy(busy), .xfer_done(xfer_done),
    .rx_word(rx_word), .link_src_ctl(link_src_ctl), .link_dst_ctl(link_dst_ctl),
    .link_data(link_data), .link_data_en(link_data_en));

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit ended   = 0;
  bit compare_on = 0;
  string tag = "R3";

  // reference model
  bit          m_busy = 0;
  bit          m_done = 0;
  int          m_mode = 0;
  int          mk, mE, mF;
  logic [DW-1:0] m_word = '0;
  logic [DW-1:0] m_rx = '0;
  int          m_dones = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rx = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        mk++;
        case (m_mode)
          0: begin
            if (mk == 4) begin m_rx = m_word; m_done = 1; end
            if (mk == 4 + SW) m_busy = 0;
          end
          1: begin
            if (mk == 3 + RD) m_word = src_word;
            if (mk == PULL_T) begin m_rx = m_word; m_done = 1; end
            if (mk == PULL_T + 3) m_busy = 0;
          end
          2: begin
            if (mE < 0 && mk >= 4 + ST && !dst_stall) begin
              mE = mk; m_rx = m_word; m_done = 1;
            end
            if (mE >= 0 && mk == mE + 9) m_busy = 0;
          end
          default: begin
            if (mF < 0 && mk >= 3 + RD && !src_stall) begin
              mF = mk; m_word = src_word;
            end
            if (mF >= 0 && mk == mF + 3 + ST) begin m_rx = m_word; m_done = 1; end
            if (mF >= 0 && mk == mF + 9 + ST) m_busy = 0;
          end
        endcase
        if (m_done) m_dones++;
      end else if (go) begin
        m_busy = 1; mk = 0; mE = -1; mF = -1;
        m_mode = int'(mode_sel); m_word = src_word;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && compare_on && !ended) begin
      string t;
      t = (tag == "") ? mode_tag(m_mode) : tag;
      check(busy == m_busy, "R7", "busy", busy, m_busy);
      check(xfer_done == m_done, "R8", "xfer_done", xfer_done, m_done);
      check(rx_word == m_rx, t, "rx_word", rx_word, m_rx);
      if (!link_data_en)
        check(link_data == '0, "R9", "idle bus", link_data, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 40000 && !ended) begin
      ended = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < 40000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_xfer(input logic [1:0] md, input logic [DW-1:0] w,
                          input logic [DW-1:0] w_late, input int dstall,
                          input int sstall);
    int n;
    int d0;
    @(negedge clk);
    mode_sel = md; src_word = w; go = 1'b1;
    dst_stall = (dstall > 0); src_stall = (sstall > 0);
    d0 = m_dones;
    @(negedge clk);
    go = 1'b0;
    n = 1;
    src_word = w_late;
    mode_sel = ~md;   // must not disturb the running transfer
    while (m_busy) begin
      @(negedge clk);
      n++;
      if (n == dstall) dst_stall = 1'b0;
      if (n == sstall) src_stall = 1'b0;
    end
    dst_stall = 1'b0; src_stall = 1'b0;
    check(m_dones - d0 == 1, tag == "" ? mode_tag(int'(md)) : tag,
          "completions", m_dones - d0, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && xfer_done == 1'b0, "R1", "busy/done", {busy, xfer_done}, 0);
    check(rx_word == '0 && link_data == '0, "R1", "words", rx_word, 0);
    check(!link_src_ctl && !link_dst_ctl && !link_data_en, "R1", "link lines",
          {link_src_ctl, link_dst_ctl, link_data_en}, 0);
    rst_n = 1'b1;
    compare_on = 1;

    tag = "";
    run_xfer(2'b00, 8'hA5, 8'h11, 0, 0);
    run_xfer(2'b00, 8'h3C, 8'h22, 0, 0);
    run_xfer(2'b01, 8'h77, 8'h5E, 0, 0);   // word taken at response edge
    run_xfer(2'b01, 8'h01, 8'hFE, 0, 0);
    run_xfer(2'b10, 8'hC3, 8'h44, 0, 0);
    run_xfer(2'b10, 8'h96, 8'h12, 12, 0);  // receiver stall
    run_xfer(2'b10, 8'h69, 8'h13, 6, 0);   // stall lifts right at settle end
    run_xfer(2'b11, 8'h5A, 8'h8B, 0, 0);
    run_xfer(2'b11, 8'h24, 8'hD7, 0, 10);  // sender stall
    run_xfer(2'b11, 8'h42, 8'h99, 0, 5);

    // R10 stalls held high in styles where they must be ignored
    tag = "R10";
    run_xfer(2'b00, 8'hE1, 8'h0F, 60, 60);
    run_xfer(2'b01, 8'hE2, 8'h1F, 60, 60);
    run_xfer(2'b10, 8'hE3, 8'h2F, 0, 60);
    run_xfer(2'b11, 8'hE4, 8'h3F, 60, 0);

    // R2 go held across the busy release edge, mode changed mid-transfer
    tag = "R2";
    @(negedge clk);
    mode_sel = 2'b00; src_word = 8'hB0; go = 1'b1;
    @(negedge clk);
    mode_sel = 2'b11; src_word = 8'hB1;
    while (m_busy) @(negedge clk);
    check(!busy, "R2", "release edge ignores go", busy, 0);
    @(negedge clk);
    check(busy && m_mode == 3, "R2", "restart in new mode", busy, 1);
    go = 1'b0;
    while (m_busy) @(negedge clk);
    check(rx_word == 8'hB1, "R2", "second word", rx_word, 8'hB1);
    repeat (4) @(negedge clk);

    compare_on = 0;
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule